// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block maps each incoming transaction address onto one of a bank of programmable address windows. It returns the 4-bit target identifier of the selected window, the index of that window, and whether the access is allowed. Each window has an enable, a target identifier, an inclusive low and high bound at 1 MB granularity, and four secure-only flags. Software programs these through a simple 32-bit register port.

Window 0 is reserved for configuration space. It always spans 16 MB upward from its low bound, ignores its high bound register, and stays enabled whatever software writes. A lookup is presented with a valid strobe, a 48-bit address, a read/write flag and a secure flag. The registered result follows one cycle later. When several windows overlap, the lowest-numbered one wins. A non-secure data access to a window marked secure-only for that direction is refused.

The block holds no state machine. Its only sequential behaviour is the register file and a single result register, which is loaded by each lookup strobe. The result is classified as one of three named outcomes, miss, hit or denied, and the output register is loaded according to that class.

Top module: `addrwin_decoder`

## Requirements
- R1: After reset, window 0 reads control 0x00000001 and its low bound register holds CFG_BASE_MB in bits [31:4]. Windows 1 to 23 read zero in every register. All lookup outputs are zero.
- R2: Window w owns byte addresses 0x20*w to 0x20*w+0x1F. Offset 0x0 is control, with bit 0 the enable and bits [11:8] the target ID. Offset 0x4 is security, using bits [3:0]. Offset 0x8 is the low bound and offset 0xC the high bound, each holding address bits [47:20] in register bits [31:4] with bits [3:0] reading zero. Read data appears the cycle after reg_rd.
- R3: A window w ≥ 1 matches when it is enabled and low ≤ addr[47:20] ≤ high, both bounds inclusive.
- R4: Window 0 matches addr[47:20] from low to low+15, whatever its high bound register holds. Writing 0 to its enable bit leaves it enabled and reading 1.
- R5: When several windows match, the result names the lowest-numbered one.
- R6: When no window matches, lk_hit, lk_target, lk_index and lk_denied are all zero.
- R7: A non-secure lookup is refused when it is a data write to a window with security bit 2 set, or a data read with security bit 3 set. A refused lookup gives lk_denied=1, lk_hit=0, lk_target=0 and lk_index=the window index. A secure access to the same window hits.
- R8: With security bit 0 of a window set, non-secure register writes to any register of that window are ignored. With bit 1 set, non-secure register reads of that window return zero. Secure accesses are unaffected.
- R9: Register writes at a window index of 24 or more, or at offsets 0x10 to 0x1C, are ignored, and reads there return zero.
- R10: lk_done pulses one cycle after each lk_valid strobe, and the results appear in that same cycle. Between strobes the results hold and lk_done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_secure | input | 1 | Register access is secure |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Lookup address |
| lk_write | input | 1 | Lookup is a data write (0 = read) |
| lk_secure | input | 1 | Lookup is secure |
| lk_done | output | 1 | Result valid pulse |
| lk_hit | output | 1 | A window matched and access is allowed |
| lk_target | output | 4 | Target ID of the hit window |
| lk_index | output | 5 | Index of the matching window |
| lk_denied | output | 1 | Access refused by data security flags |

## Verification
Every lookup result, and its lk_done pulse, is due exactly one clock after the cycle that carries lk_valid. Register read data is due one clock after reg_rd. A driver task queues the expected lookup outcome at the falling edge where it raises the strobe. A monitor pops and compares the queued outcome at the next falling edge where lk_done is high, so that each comparison lands in the one cycle the result belongs to. Register reads are compared at the falling edge following the read strobe. The hold behaviour is checked several idle cycles after a result.

// File: rtl/addrwin_pkg.sv
`timescale 1ns/1ps
package addrwin_pkg;
    // register offsets inside a window group, in 32-bit word units
    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_SEC  = 3'd1;
    localparam logic [2:0] OFS_LO   = 3'd2;
    localparam logic [2:0] OFS_HI   = 3'd3;

    // security flag positions
    localparam int SEC_CW = 0;  // register writes secure-only
    localparam int SEC_CR = 1;  // register reads secure-only
    localparam int SEC_DW = 2;  // data writes secure-only
    localparam int SEC_DR = 3;  // data reads secure-only

    typedef enum logic [1:0] {
        RES_MISS = 2'd0,
        RES_HIT  = 2'd1,
        RES_DENY = 2'd2
    } res_kind_t;
endpackage

// File: rtl/addrwin_regfile.sv
`timescale 1ns/1ps
module addrwin_regfile
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN     = 24,
    parameter int TGT_W       = 4,
    parameter int BND_W       = 28,
    parameter int RADDR_W     = 12,
    parameter logic [BND_W-1:0] CFG_BASE_MB = 28'h0000F00,
    localparam int IDX_W      = $clog2(NUM_WIN),
    localparam int WIDX_W     = RADDR_W - 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic               reg_secure,
    output logic [31:0]        reg_rdata,
    output logic [NUM_WIN-1:0] win_en,
    output logic [TGT_W-1:0]   win_tgt [NUM_WIN],
    output logic [3:0]         win_sec [NUM_WIN],
    output logic [BND_W-1:0]   win_lo  [NUM_WIN],
    output logic [BND_W-1:0]   win_hi  [NUM_WIN]
);
    logic [WIDX_W-1:0] widx;
    logic [2:0]        ofs;
    logic              idx_ok;
    logic [IDX_W-1:0]  sel;
    logic              wr_ok, rd_ok;
    logic [31:0]       rd_val;
    logic              unused_lsb;

    assign widx       = reg_addr[RADDR_W-1:5];
    assign ofs        = reg_addr[4:2];
    assign unused_lsb = ^reg_addr[1:0];
    assign idx_ok     = (32'(widx) < NUM_WIN);
    assign sel        = idx_ok ? widx[IDX_W-1:0] : '0;
    assign wr_ok      = reg_wr && idx_ok && (reg_secure || !win_sec[sel][SEC_CW]);
    assign rd_ok      = reg_rd && idx_ok && (reg_secure || !win_sec[sel][SEC_CR]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                win_en[w]  <= (w == 0);
                win_tgt[w] <= '0;
                win_sec[w] <= '0;
                win_lo[w]  <= (w == 0) ? CFG_BASE_MB : '0;
                win_hi[w]  <= '0;
            end
        end else if (wr_ok) begin
            unique case (ofs)
                OFS_CTRL: begin
                    win_en[sel]  <= (sel == '0) ? 1'b1 : reg_wdata[0];
                    win_tgt[sel] <= reg_wdata[8 +: TGT_W];
                end
                OFS_SEC: win_sec[sel] <= reg_wdata[3:0];
                OFS_LO:  win_lo[sel]  <= reg_wdata[4 +: BND_W];
                OFS_HI:  win_hi[sel]  <= reg_wdata[4 +: BND_W];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (ofs)
            OFS_CTRL: begin
                rd_val[0]          = win_en[sel];
                rd_val[8 +: TGT_W] = win_tgt[sel];
            end
            OFS_SEC: rd_val[3:0]        = win_sec[sel];
            OFS_LO:  rd_val[4 +: BND_W] = win_lo[sel];
            OFS_HI:  rd_val[4 +: BND_W] = win_hi[sel];
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_ok ? rd_val : '0;
    end

    // R9
    rd_oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !idx_ok) |=> (reg_rdata == '0));

    // R4
    cfg_win_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && idx_ok && sel == '0 && ofs == OFS_CTRL) |=> win_en[0]);
endmodule

// File: rtl/addrwin_match.sv
`timescale 1ns/1ps
module addrwin_match #(
    parameter int NUM_WIN     = 24,
    parameter int ADDR_W      = 48,
    parameter int BND_W       = 28,
    parameter int CFG_SIZE_MB = 16,
    localparam int GRAN_SH    = ADDR_W - BND_W
) (
    input  logic [ADDR_W-1:0]  lk_addr,
    input  logic [NUM_WIN-1:0] win_en,
    input  logic [BND_W-1:0]   win_lo [NUM_WIN],
    input  logic [BND_W-1:0]   win_hi [NUM_WIN],
    output logic [NUM_WIN-1:0] match
);
    logic [BND_W-1:0] a_mb;
    logic             unused_bits;

    assign a_mb        = lk_addr[ADDR_W-1:GRAN_SH];
    assign unused_bits = ^{lk_addr[GRAN_SH-1:0], win_hi[0]};

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        if (w == 0) begin : g_cfg
            logic [BND_W-1:0] diff;
            assign diff     = a_mb - win_lo[0];
            assign match[0] = win_en[0] && (a_mb >= win_lo[0]) &&
                              (32'(diff) < CFG_SIZE_MB);
        end else begin : g_prog
            assign match[w] = win_en[w] && (a_mb >= win_lo[w]) && (a_mb <= win_hi[w]);
        end
    end
endmodule

// File: rtl/addrwin_select.sv
`timescale 1ns/1ps
module addrwin_select
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN = 24,
    parameter int TGT_W   = 4,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic               lk_write,
    input  logic               lk_secure,
    input  logic [NUM_WIN-1:0] match,
    input  logic [TGT_W-1:0]   win_tgt [NUM_WIN],
    input  logic [3:0]         win_sec [NUM_WIN],
    output logic               lk_done,
    output logic               lk_hit,
    output logic [TGT_W-1:0]   lk_target,
    output logic [IDX_W-1:0]   lk_index,
    output logic               lk_denied
);
    logic [IDX_W-1:0] first;
    logic             any;
    logic             refuse;
    res_kind_t        kind;
    logic             unused_sec;

    always_comb begin
        first = '0;
        any   = 1'b0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (match[w]) begin
                first = IDX_W'(w);
                any   = 1'b1;
            end
        end
    end

    always_comb begin
        unused_sec = 1'b0;
        for (int w = 0; w < NUM_WIN; w++) unused_sec = unused_sec ^ (^win_sec[w][1:0]);
    end

    assign refuse = !lk_secure &&
                    (lk_write ? win_sec[first][SEC_DW] : win_sec[first][SEC_DR]);

    always_comb begin
        if (!any)        kind = RES_MISS;
        else if (refuse) kind = RES_DENY;
        else             kind = RES_HIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_done   <= 1'b0;
            lk_hit    <= 1'b0;
            lk_target <= '0;
            lk_index  <= '0;
            lk_denied <= 1'b0;
        end else begin
            lk_done <= lk_valid;
            if (lk_valid) begin
                unique case (kind)
                    RES_HIT: begin
                        lk_hit    <= 1'b1;
                        lk_target <= win_tgt[first];
                        lk_index  <= first;
                        lk_denied <= 1'b0;
                    end
                    RES_DENY: begin
                        lk_hit    <= 1'b0;
                        lk_target <= '0;
                        lk_index  <= first;
                        lk_denied <= 1'b1;
                    end
                    default: begin
                        lk_hit    <= 1'b0;
                        lk_target <= '0;
                        lk_index  <= '0;
                        lk_denied <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R10
    done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done == $past(lk_valid));

    // R10
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> ($stable(lk_hit) && $stable(lk_target) && $stable(lk_denied)));

    // R7
    hit_deny_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_denied));

    // R6
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && !lk_hit && !lk_denied) |-> (lk_target == '0 && lk_index == '0));
endmodule

// File: rtl/addrwin_decoder.sv
`timescale 1ns/1ps
module addrwin_decoder #(
    parameter int NUM_WIN     = 24,
    parameter int ADDR_W      = 48,
    parameter int TGT_W       = 4,
    parameter int RADDR_W     = 12,
    parameter int CFG_SIZE_MB = 16,
    parameter logic [ADDR_W-21:0] CFG_BASE_MB = 28'h0000F00,
    localparam int BND_W      = ADDR_W - 20,
    localparam int IDX_W      = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic               reg_secure,
    output logic [31:0]        reg_rdata,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    input  logic               lk_write,
    input  logic               lk_secure,
    output logic               lk_done,
    output logic               lk_hit,
    output logic [TGT_W-1:0]   lk_target,
    output logic [IDX_W-1:0]   lk_index,
    output logic               lk_denied
);
    logic [NUM_WIN-1:0] win_en;
    logic [TGT_W-1:0]   win_tgt [NUM_WIN];
    logic [3:0]         win_sec [NUM_WIN];
    logic [BND_W-1:0]   win_lo  [NUM_WIN];
    logic [BND_W-1:0]   win_hi  [NUM_WIN];
    logic [NUM_WIN-1:0] match;

    addrwin_regfile #(
        .NUM_WIN(NUM_WIN), .TGT_W(TGT_W), .BND_W(BND_W),
        .RADDR_W(RADDR_W), .CFG_BASE_MB(CFG_BASE_MB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_secure(reg_secure),
        .reg_rdata(reg_rdata), .win_en(win_en), .win_tgt(win_tgt),
        .win_sec(win_sec), .win_lo(win_lo), .win_hi(win_hi)
    );

    addrwin_match #(
        .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .BND_W(BND_W), .CFG_SIZE_MB(CFG_SIZE_MB)
    ) u_match (
        .lk_addr(lk_addr), .win_en(win_en), .win_lo(win_lo),
        .win_hi(win_hi), .match(match)
    );

    addrwin_select #(
        .NUM_WIN(NUM_WIN), .TGT_W(TGT_W)
    ) u_sel (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
        .lk_secure(lk_secure), .match(match), .win_tgt(win_tgt), .win_sec(win_sec),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_target(lk_target),
        .lk_index(lk_index), .lk_denied(lk_denied)
    );
endmodule

// File: tb/test_addrwin_decoder.sv
`timescale 1ns/1ps
module test_addrwin_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_secure = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0, lk_write = 1'b0, lk_secure = 1'b0;
    logic [47:0] lk_addr = '0;
    logic        lk_done, lk_hit, lk_denied;
    logic [3:0]  lk_target;
    logic [4:0]  lk_index;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        bit         hit;
        logic [3:0] tgt;
        logic [4:0] idx;
        bit         den;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    addrwin_decoder i_addrwin_decoder (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_secure(reg_secure),
        .reg_rdata(reg_rdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_write(lk_write), .lk_secure(lk_secure), .lk_done(lk_done),
        .lk_hit(lk_hit), .lk_target(lk_target), .lk_index(lk_index),
        .lk_denied(lk_denied)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d, input bit sec);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_secure = sec;
        @(negedge clk);
        reg_wr = 1'b0; reg_secure = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, input bit sec, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a; reg_secure = sec;
        @(negedge clk);
        reg_rd = 1'b0; reg_secure = 1'b0;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    // driver: queue expectation, present one lookup strobe
    task automatic lookup(input logic [27:0] mb, input bit wr, input bit sec,
                          input bit eh, input logic [3:0] et, input logic [4:0] ei,
                          input bit ed, input string tag);
        exp_t e;
        e.hit = eh; e.tgt = et; e.idx = ei; e.den = ed; e.tag = tag;
        @(negedge clk);
        sb.push_back(e);
        lk_valid = 1'b1; lk_addr = {mb, 20'h5A3C1}; lk_write = wr; lk_secure = sec;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // monitor: compare each result in the cycle it is due
    always @(negedge clk) begin
        if (rst_n && lk_done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10 unexpected lk_done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(lk_hit === e.hit,    {e.tag, " hit"},    32'(lk_hit),    32'(e.hit));
                chk(lk_target === e.tgt, {e.tag, " target"}, 32'(lk_target), 32'(e.tgt));
                chk(lk_index === e.idx,  {e.tag, " index"},  32'(lk_index),  32'(e.idx));
                chk(lk_denied === e.den, {e.tag, " denied"}, 32'(lk_denied), 32'(e.den));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(lk_done === 1'b0 && lk_hit === 1'b0 && lk_denied === 1'b0, "R1 lookup outs after reset",
            {lk_done, lk_hit, lk_denied}, 32'd0);
        chk(lk_target === 4'd0 && lk_index === 5'd0, "R1 target/index after reset",
            {lk_target, lk_index}, 32'd0);
        reg_read(12'h000, 1'b0, 32'h0000_0001, "R1 win0 control");
        reg_read(12'h008, 1'b0, 32'h0000_F000, "R1 win0 low bound");
        reg_read(12'h0A0, 1'b0, 32'h0,         "R1 win5 control");
        reg_read(12'h0A4, 1'b0, 32'h0,         "R1 win5 security");
        reg_read(12'h0AC, 1'b0, 32'h0,         "R1 win5 high bound");

        // R4 configuration window extent
        lookup(28'h0F00, 1'b0, 1'b0, 1'b1, 4'd0, 5'd0, 1'b0, "R4 cfg first MB");
        lookup(28'h0F0F, 1'b0, 1'b0, 1'b1, 4'd0, 5'd0, 1'b0, "R4 cfg last MB");
        lookup(28'h0F10, 1'b0, 1'b0, 1'b0, 4'd0, 5'd0, 1'b0, "R4 cfg past end");
        lookup(28'h0EFF, 1'b0, 1'b0, 1'b0, 4'd0, 5'd0, 1'b0, "R6 below cfg");

        // R2 programming window 1 and readback
        reg_write(12'h020, 32'h0000_0301, 1'b0);
        reg_write(12'h028, 32'h0000_1000, 1'b0);
        reg_write(12'h02C, 32'h0000_1FFF, 1'b0);
        reg_read(12'h020, 1'b0, 32'h0000_0301, "R2 win1 control");
        reg_read(12'h028, 1'b0, 32'h0000_1000, "R2 win1 low");
        reg_read(12'h02C, 1'b0, 32'h0000_1FF0, "R2 win1 high low nibble zero");

        // R3 inclusive bounds
        lookup(28'h0100, 1'b0, 1'b0, 1'b1, 4'd3, 5'd1, 1'b0, "R3 at low");
        lookup(28'h01FF, 1'b1, 1'b0, 1'b1, 4'd3, 5'd1, 1'b0, "R3 at high");
        lookup(28'h0200, 1'b0, 1'b0, 1'b0, 4'd0, 5'd0, 1'b0, "R3 above high");
        lookup(28'h00FF, 1'b0, 1'b0, 1'b0, 4'd0, 5'd0, 1'b0, "R3 below low");

        // R5 overlap priority
        reg_write(12'h040, 32'h0000_0501, 1'b0);
        reg_write(12'h048, 32'h0000_1800, 1'b0);
        reg_write(12'h04C, 32'h0000_2FF0, 1'b0);
        lookup(28'h0180, 1'b0, 1'b0, 1'b1, 4'd3, 5'd1, 1'b0, "R5 overlap lowest wins");
        lookup(28'h0250, 1'b0, 1'b0, 1'b1, 4'd5, 5'd2, 1'b0, "R5 only win2");

        // R4 enable of window 0 sticks, high bound ignored
        reg_write(12'h000, 32'h0000_0700, 1'b0);
        reg_write(12'h00C, 32'h0000_0000, 1'b0);
        reg_read(12'h000, 1'b0, 32'h0000_0701, "R4 win0 enable cannot clear");
        lookup(28'h0F08, 1'b0, 1'b0, 1'b1, 4'd7, 5'd0, 1'b0, "R4 cfg hit new target");

        // R3 disable window 1
        reg_write(12'h020, 32'h0000_0300, 1'b0);
        lookup(28'h0100, 1'b0, 1'b0, 1'b0, 4'd0, 5'd0, 1'b0, "R3 disabled window misses");
        lookup(28'h0180, 1'b0, 1'b0, 1'b1, 4'd5, 5'd2, 1'b0, "R5 falls to next window");

        // R7 data security
        reg_write(12'h044, 32'h0000_0004, 1'b0);
        lookup(28'h0200, 1'b1, 1'b0, 1'b0, 4'd0, 5'd2, 1'b1, "R7 nonsecure write denied");
        lookup(28'h0200, 1'b1, 1'b1, 1'b1, 4'd5, 5'd2, 1'b0, "R7 secure write allowed");
        lookup(28'h0200, 1'b0, 1'b0, 1'b1, 4'd5, 5'd2, 1'b0, "R7 nonsecure read allowed");
        reg_write(12'h044, 32'h0000_0008, 1'b0);
        lookup(28'h0200, 1'b0, 1'b0, 1'b0, 4'd0, 5'd2, 1'b1, "R7 nonsecure read denied");
        lookup(28'h0200, 1'b1, 1'b0, 1'b1, 4'd5, 5'd2, 1'b0, "R7 nonsecure write allowed");

        // R10 hold between strobes
        repeat (3) @(negedge clk);
        chk(lk_done === 1'b0, "R10 done low while idle", 32'(lk_done), 32'd0);
        chk(lk_hit === 1'b1 && lk_target === 4'd5, "R10 result held",
            {lk_hit, lk_target}, {1'b1, 4'd5});

        // R8 register access security
        reg_write(12'h044, 32'h0000_000B, 1'b1);
        reg_write(12'h040, 32'h0000_0000, 1'b0);
        reg_write(12'h048, 32'h0000_0000, 1'b0);
        reg_read(12'h040, 1'b1, 32'h0000_0501, "R8 nonsecure ctrl write ignored");
        reg_read(12'h048, 1'b1, 32'h0000_1800, "R8 nonsecure low write ignored");
        reg_read(12'h040, 1'b0, 32'h0,         "R8 nonsecure read returns zero");
        reg_read(12'h044, 1'b1, 32'h0000_000B, "R8 secure read of security");
        reg_write(12'h044, 32'h0000_0000, 1'b0);
        reg_read(12'h044, 1'b1, 32'h0000_000B, "R8 nonsecure security write ignored");
        reg_write(12'h048, 32'h0000_1400, 1'b1);
        reg_read(12'h048, 1'b1, 32'h0000_1400, "R8 secure write applies");

        // R9 out of range
        reg_write(12'h300, 32'h0000_0301, 1'b1);
        reg_read(12'h300, 1'b1, 32'h0, "R9 window 24 control reads zero");
        reg_write(12'h308, 32'h0000_1000, 1'b1);
        reg_read(12'h308, 1'b1, 32'h0, "R9 window 24 low reads zero");
        reg_write(12'h030, 32'hFFFF_FFFF, 1'b0);
        reg_read(12'h030, 1'b0, 32'h0, "R9 offset 0x10 reads zero");
        reg_read(12'h020, 1'b0, 32'h0000_0300, "R9 neighbour untouched");
        lookup(28'h0F00, 1'b0, 1'b0, 1'b1, 4'd7, 5'd0, 1'b0, "R9 map unchanged");

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R10 all results delivered", sb.size(), 32'd0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule